// File: doc/BRIEF.md
# Dual Data Pointer Register Unit

This unit holds two 16-bit data pointers for an 8-bit controller core and a small select register that decides which pointer is live. The core sees the live pointer on a 16-bit address output. It uses that address for table reads relative to code, for moves to and from external data memory, and for indirect jumps. The core can also add one to the live pointer in a single cycle, or overwrite the live pointer with a 16-bit constant.

Software reaches the same state through a byte-wide special-function-register port. Three addresses are decoded: the low byte of the live pointer, its high byte, and the select register. Every other address reads as zero and ignores writes. The port supports plain writes and an 8-bit read-modify-write increment.

In the select register, bit 0 is the pointer select. Bits 3 and 4 are plain storage. Bits 1, 2 and 5 to 7 are not implemented and always read as zero. This layout gives a useful side effect. Incrementing the select register through the byte port flips the select and nothing else: when the select is 1, the carry lands in bit 1, which cannot hold a value, and so it never reaches bit 3.

Top module: `dual_dptr_unit`

## Requirements
- R1: After reset both pointers are 0000h, the select register reads 00h, `ptr_sel` is 0 and `ptr_addr` is 0000h.
- R2: `ptr_addr` always equals pointer 0 when select bit 0 is 0 and pointer 1 when it is 1, and `ptr_sel` mirrors that bit.
- R3: A write to the select register at address A2h stores bits 0, 3 and 4 of the data. Reads of that address return those three bits, with bits 1, 2, 5, 6 and 7 always 0.
- R4: Addresses 82h and 83h read and write the low and high byte of the selected pointer only. The other byte and the unselected pointer keep their values.
- R5: A `ptr_step` pulse adds one to the full 16-bit selected pointer, with the carry passing from the low byte into the high byte in the same cycle. FFFFh wraps to 0000h, and the other pointer is unchanged.
- R6: A `ptr_load` pulse writes `ptr_load_val` into the selected pointer only.
- R7: An `sfr_inc` pulse at address A2h inverts select bit 0 and leaves bits 3 and 4 unchanged.
- R8: An `sfr_inc` pulse at 82h or 83h adds one to that byte of the selected pointer modulo 256. No carry passes into the other byte.
- R9: Any other address reads 00h, and a write or increment there changes no pointer and no select bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | Byte-port register address |
| sfr_wr | input | 1 | Write `sfr_wdata` to the addressed register |
| sfr_inc | input | 1 | Add one to the addressed register |
| sfr_wdata | input | 8 | Byte-port write data |
| sfr_rdata | output | 8 | Byte-port read data for `sfr_addr`, combinational |
| ptr_step | input | 1 | Add one to the selected 16-bit pointer |
| ptr_load | input | 1 | Load `ptr_load_val` into the selected pointer |
| ptr_load_val | input | 16 | Constant for the load operation |
| ptr_addr | output | 16 | Value of the selected pointer |
| ptr_sel | output | 1 | Index of the selected pointer |

## Verification
The assertions assume that at most one of `sfr_wr`, `sfr_inc`, `ptr_step` and `ptr_load` is high in any cycle. Under that assumption the select cannot change in the same cycle as a pointer update, so the idle pointer is a fixed register while any pointer operation takes effect. The stimulus keeps to this by issuing exactly one operation per cycle and clearing all strobes before the next one. It chooses among the decoded addresses and a random undecoded one, so the random phase covers both selects and all four operation kinds.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Bits of the select register that hold state: select (0) and storage (3, 4)
  localparam byte_t SEL_KEEP = 8'b0001_1001;

  function automatic byte_t sel_clean(byte_t v);
    return v & SEL_KEEP;
  endfunction

  function automatic byte_t byte_step(byte_t v);
    return v + byte_t'(1);
  endfunction
endpackage

// File: rtl/dptr_select_reg.sv
module dptr_select_reg
  import dptr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  logic  bump,
  input  byte_t wdata,
  output logic  sel,
  output byte_t rdata
);
  byte_t sel_q;
  byte_t sel_next;

  always_comb begin
    sel_next = sel_q;
    if (wr)        sel_next = sel_clean(wdata);
    else if (bump) sel_next = sel_clean(byte_step(sel_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_next;
  end

  assign sel   = sel_q[0];
  assign rdata = sel_q;

  // R3
  sel_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (rdata[7:5] == 3'b000) && (rdata[2:1] == 2'b00));

  // R7
  sel_bump_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !wr) |=> (sel != $past(sel)) && (rdata[4:3] == $past(rdata[4:3])));
endmodule

// File: rtl/dptr_bank.sv
module dptr_bank #(
  parameter int PTR_W   = 16,
  parameter int NUM_PTR = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NUM_PTR)-1:0] sel,
  input  logic                     load,
  input  logic [PTR_W-1:0]         load_val,
  input  logic                     step16,
  input  logic                     wr_lo,
  input  logic                     wr_hi,
  input  logic                     bump_lo,
  input  logic                     bump_hi,
  input  logic [PTR_W/2-1:0]       wdata,
  output logic [PTR_W-1:0]         active_q,
  output logic [PTR_W-1:0]         idle_q
);
  localparam int SEL_W = $clog2(NUM_PTR);
  localparam int HALF  = PTR_W / 2;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  function automatic logic [HALF-1:0] half_next(logic [HALF-1:0] h);
    return h + HALF'(1);
  endfunction

  logic [NUM_PTR-1:0][PTR_W-1:0] ptr_all;
  logic [SEL_W-1:0]              idle_idx;
  logic                          bank_touch;

  assign bank_touch = load | step16 | wr_lo | wr_hi | bump_lo | bump_hi;
  assign idle_idx   = sel + SEL_W'(1);

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic             hit;
    logic [PTR_W-1:0] q;
    logic [PTR_W-1:0] d;

    assign hit = (sel == SEL_W'(g));

    always_comb begin
      d = q;
      if (hit) begin
        if (load)         d = load_val;
        else if (step16)  d = ptr_next(q);
        else if (wr_lo)   d[HALF-1:0] = wdata;
        else if (wr_hi)   d[PTR_W-1:HALF] = wdata;
        else if (bump_lo) d[HALF-1:0] = half_next(q[HALF-1:0]);
        else if (bump_hi) d[PTR_W-1:HALF] = half_next(q[PTR_W-1:HALF]);
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign ptr_all[g] = q;
  end

  assign active_q = ptr_all[sel];
  assign idle_q   = ptr_all[idle_idx];

  // R5
  step_adds_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step16 && !load) |=> active_q == $past(active_q) + PTR_W'(1));

  // R6
  load_takes_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active_q == $past(load_val));

  // R4
  idle_ptr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_touch |=> $stable(idle_q));

  // R8
  bump_lo_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bump_lo && !(load || step16 || wr_lo || wr_hi))
      |=> active_q[PTR_W-1:HALF] == $past(active_q[PTR_W-1:HALF]));
endmodule

// File: rtl/dual_dptr_unit.sv
module dual_dptr_unit
  import dptr_pkg::*;
#(
  parameter int         PTR_W    = 16,
  parameter logic [7:0] ADDR_LO  = 8'h82,
  parameter logic [7:0] ADDR_HI  = 8'h83,
  parameter logic [7:0] ADDR_SEL = 8'hA2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       sfr_addr,
  input  logic             sfr_wr,
  input  logic             sfr_inc,
  input  logic [7:0]       sfr_wdata,
  output logic [7:0]       sfr_rdata,
  input  logic             ptr_step,
  input  logic             ptr_load,
  input  logic [PTR_W-1:0] ptr_load_val,
  output logic [PTR_W-1:0] ptr_addr,
  output logic             ptr_sel
);
  localparam int HALF = PTR_W / 2;

  logic             hit_lo, hit_hi, hit_sel;
  logic             sel_bit;
  byte_t            sel_rdata;
  logic [PTR_W-1:0] live_ptr, idle_ptr;

  assign hit_lo  = (sfr_addr == ADDR_LO);
  assign hit_hi  = (sfr_addr == ADDR_HI);
  assign hit_sel = (sfr_addr == ADDR_SEL);

  dptr_select_reg i_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (sfr_wr  && hit_sel),
    .bump  (sfr_inc && hit_sel),
    .wdata (sfr_wdata),
    .sel   (sel_bit),
    .rdata (sel_rdata)
  );

  dptr_bank #(.PTR_W(PTR_W), .NUM_PTR(2)) i_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel_bit),
    .load     (ptr_load),
    .load_val (ptr_load_val),
    .step16   (ptr_step),
    .wr_lo    (sfr_wr  && hit_lo),
    .wr_hi    (sfr_wr  && hit_hi),
    .bump_lo  (sfr_inc && hit_lo),
    .bump_hi  (sfr_inc && hit_hi),
    .wdata    (sfr_wdata),
    .active_q (live_ptr),
    .idle_q   (idle_ptr)
  );

  always_comb begin
    sfr_rdata = '0;
    if (hit_lo)       sfr_rdata = live_ptr[HALF-1:0];
    else if (hit_hi)  sfr_rdata = live_ptr[PTR_W-1:HALF];
    else if (hit_sel) sfr_rdata = sel_rdata;
  end

  assign ptr_addr = live_ptr;
  assign ptr_sel  = sel_bit;

  // input assumption: one operation per cycle
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sfr_wr, sfr_inc, ptr_step, ptr_load}));

  // R2
  sel_swap_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_sel != $past(ptr_sel)) |-> ptr_addr == $past(idle_ptr));

  // R9
  undecoded_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sfr_wr || sfr_inc) && !hit_lo && !hit_hi && !hit_sel)
      |=> $stable(ptr_addr) && $stable(ptr_sel));
endmodule

// File: tb/test_dual_dptr_unit.sv
`timescale 1ns/100ps
module test_dual_dptr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
  logic        sfr_wr, sfr_inc, ptr_step, ptr_load, ptr_sel;
  logic [15:0] ptr_load_val, ptr_addr;

  int checks = 0;
  int failures = 0;

  logic [15:0] m_ptr [2];
  logic [7:0]  m_sel;

  always #2.5 clk = ~clk;

  dual_dptr_unit i_dual_dptr_unit (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_inc(sfr_inc), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .ptr_step(ptr_step), .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
    .ptr_addr(ptr_addr), .ptr_sel(ptr_sel)
  );

  function automatic logic [7:0] keep_sel_bits(logic [7:0] d);
    return {3'b000, d[4], d[3], 2'b00, d[0]};
  endfunction

  function automatic logic [7:0] other_addr(logic [7:0] a);
    return (a == 8'h82 || a == 8'h83 || a == 8'hA2) ? 8'h81 : a;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic read_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    sfr_addr = a;
    #0.2;
    chk(tag, {8'h00, sfr_rdata}, {8'h00, exp});
  endtask

  task automatic verify_all(input string tag);
    logic [15:0] live;
    live = m_ptr[m_sel[0]];
    chk(tag, ptr_addr, live);
    chk(tag, {15'd0, ptr_sel}, {15'd0, m_sel[0]});
    read_chk(tag, 8'h82, live[7:0]);
    read_chk(tag, 8'h83, live[15:8]);
    read_chk(tag, 8'hA2, m_sel);
    read_chk("R9", other_addr(8'($urandom)), 8'h00);
  endtask

  // kind: 0 byte write, 1 byte increment, 2 pointer step, 3 pointer load
  task automatic run_op(input int kind, input logic [7:0] a, input logic [7:0] d,
                        input logic [15:0] v, input string tag);
    logic s;
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; ptr_load_val = v;
    sfr_wr = (kind == 0); sfr_inc = (kind == 1);
    ptr_step = (kind == 2); ptr_load = (kind == 3);
    @(negedge clk);
    sfr_wr = 1'b0; sfr_inc = 1'b0; ptr_step = 1'b0; ptr_load = 1'b0;
    s = m_sel[0];
    case (kind)
      0: if (a == 8'h82) m_ptr[s][7:0] = d;
         else if (a == 8'h83) m_ptr[s][15:8] = d;
         else if (a == 8'hA2) m_sel = keep_sel_bits(d);
      1: if (a == 8'h82) m_ptr[s][7:0] = m_ptr[s][7:0] + 8'd1;
         else if (a == 8'h83) m_ptr[s][15:8] = m_ptr[s][15:8] + 8'd1;
         else if (a == 8'hA2) m_sel[0] = ~m_sel[0];
      2: m_ptr[s] = m_ptr[s] + 16'd1;
      default: m_ptr[s] = v;
    endcase
    verify_all(tag);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; sfr_addr = 8'h00; sfr_wdata = 8'h00; ptr_load_val = 16'h0000;
    sfr_wr = 1'b0; sfr_inc = 1'b0; ptr_step = 1'b0; ptr_load = 1'b0;
    m_ptr[0] = 16'h0000; m_ptr[1] = 16'h0000; m_sel = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    verify_all("R1");

    // directed corners
    run_op(3, 8'h00, 8'h00, 16'hFFFF, "R6");
    run_op(2, 8'h00, 8'h00, 16'h0000, "R5");   // wrap to 0000
    run_op(3, 8'h00, 8'h00, 16'h12FF, "R6");
    run_op(2, 8'h00, 8'h00, 16'h0000, "R5");   // carry into high byte
    run_op(3, 8'h00, 8'h00, 16'h34FF, "R6");
    run_op(1, 8'h82, 8'h00, 16'h0000, "R8");   // low byte wraps, no carry
    run_op(1, 8'h83, 8'h00, 16'h0000, "R8");
    run_op(0, 8'hA2, 8'hFF, 16'h0000, "R3");   // reads back 19h
    run_op(0, 8'h82, 8'hA5, 16'h0000, "R4");   // pointer 1 low byte
    run_op(1, 8'hA2, 8'h00, 16'h0000, "R7");   // back to pointer 0, bits 3,4 kept
    chk("R2", ptr_addr, 16'h3500);
    run_op(1, 8'hA2, 8'h00, 16'h0000, "R7");
    chk("R4", ptr_addr, 16'h00A5);
    run_op(0, 8'h81, 8'h55, 16'h0000, "R9");
    run_op(1, 8'hFE, 8'h00, 16'h0000, "R9");

    // constrained random
    for (int i = 0; i < 600; i++) begin
      int kind;
      int pick;
      logic [7:0] a;
      string tag;
      kind = int'($urandom % 4);
      pick = int'($urandom % 5);
      a = (pick == 0) ? 8'h82 : (pick == 1) ? 8'h83 :
          (pick == 4) ? other_addr(8'($urandom)) : 8'hA2;
      if (kind == 2) tag = "R5";
      else if (kind == 3) tag = "R6";
      else if (a == 8'hA2) tag = (kind == 0) ? "R3" : "R7";
      else if (a == 8'h82 || a == 8'h83) tag = (kind == 0) ? "R4" : "R8";
      else tag = "R9";
      run_op(kind, a, 8'($urandom), 16'($urandom), tag);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule